// File: doc/BRIEF.md
# Debug UART Transceiver with Command-Driven Direction Control

A full-duplex asynchronous serial port for bring-up and debug consoles. One transmitter and one receiver share a 16x oversampling tick. Each frame has a start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. Software drives the block through a write-only command word and a holding-register write port. It reads received bytes through a data output and a read strobe.

The command word controls each direction with separate reset, enable and disable bits, and also has a status-clear bit. A reset acts at once: it aborts any frame in progress and leaves that direction disabled. A disable is graceful. The receiver finishes the frame it is taking in. The transmitter sends both the frame it is shifting and any byte waiting in the holding register, then stops. An enable is ignored when the disable bit of the same direction is also set in that write, and a reset outranks both. The receiver flags parity, framing and overrun errors, which stay set until a status-clear command.

Top module: `dbg_uart`

## Requirements
- R1: Command word bit map: bit 2 receiver reset, bit 3 transmitter reset, bit 4 receiver enable, bit 5 receiver disable, bit 6 transmitter enable, bit 7 transmitter disable, bit 8 status clear. A 0 in any bit, and any value in bits 0 and 1, has no effect.
- R2: A transmitter reset returns `txd` to 1 on the next cycle, cuts off the frame being sent, discards the holding byte and disables the transmitter.
- R3: A receiver reset discards a partly received frame at once and disables the receiver, so that later frames are not received.
- R4: An enable bit has no effect when the disable bit of the same direction is set in the same write.
- R5: A reset bit has priority over an enable or disable bit of the same direction in the same write.
- R6: A transmitter disable without reset lets the frame being shifted and a byte already in the holding register both go out. After that the transmitter stays idle and disabled.
- R7: A receiver disable without reset lets a frame already in progress complete and be delivered. Later frames are ignored.
- R8: Transmit frame: start bit 0, eight data bits LSB first, a parity bit when `par_en`=1 (value is the XOR of the data bits, inverted when `par_odd`=1), then stop bit 1. Each bit lasts 16 ticks.
- R9: The receiver samples each bit 8 ticks into the bit (mid-bit), shifting data in LSB first. It drops a start bit that is high again at mid-bit, and raises `rx_ready` with the byte on `rx_data` when a frame completes.
- R10: `frm_err` sets when the stop bit samples 0. `par_err` sets when parity is enabled and the received parity bit differs from the R8 rule.
- R11: `ovr_err` sets when a frame completes while `rx_ready` is still 1 and `rx_rd` is not asserted in that cycle. The new byte replaces the old one.
- R12: A status clear zeroes `par_err`, `frm_err` and `ovr_err` on the next cycle, winning over a same-cycle set. It leaves `rx_ready` and `rx_data` unchanged.
- R13: `tx_ready` is 1 exactly when the transmitter is enabled, has no disable pending and its holding register is empty. Holding-register writes while `tx_ready` is 0 are ignored.
- R14: `rx_rd` clears `rx_ready` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 9 | Command word (bit map in R1) |
| thr_we | input | 1 | Holding-register write strobe |
| thr_wdata | input | 8 | Byte to transmit |
| par_en | input | 1 | Parity bit present in frames |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| rxd | input | 1 | Serial receive line |
| rx_rd | input | 1 | Read strobe for the received byte |
| txd | output | 1 | Serial transmit line |
| tx_ready | output | 1 | Holding register can accept a byte |
| rx_data | output | 8 | Last received byte |
| rx_ready | output | 1 | Unread byte present |
| par_err | output | 1 | Parity error flag |
| frm_err | output | 1 | Framing error flag |
| ovr_err | output | 1 | Overrun flag |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse and that `par_en` and `par_odd` change only between frames. The bench generates the tick as one cycle in four and alters the parity setting only while both directions are idle. The assertions also assume that software never sends a command on a cycle that depends on a tick edge. The bench drives commands and `rx_rd` on falling clock edges, some at deliberately chosen points in the middle of a frame. It does not issue a status clear and a read in the same cycle as a frame completion, so each flag has one expected value.

// File: rtl/dbg_uart_pkg.sv
package dbg_uart_pkg;
    // Command word layout
    localparam int CMD_W       = 9;
    localparam int CMD_RX_RST  = 2;
    localparam int CMD_TX_RST  = 3;
    localparam int CMD_RX_EN   = 4;
    localparam int CMD_RX_DIS  = 5;
    localparam int CMD_TX_EN   = 6;
    localparam int CMD_TX_DIS  = 7;
    localparam int CMD_STA_CLR = 8;

    typedef enum logic [2:0] {
        FR_IDLE  = 3'd0,
        FR_START = 3'd1,
        FR_DATA  = 3'd2,
        FR_PAR   = 3'd3,
        FR_STOP  = 3'd4
    } frame_st_e;

    // Resolved per-direction command: at most one of the three is set
    typedef struct packed {
        logic rst;
        logic en;
        logic dis;
    } dir_cmd_t;
endpackage

// File: rtl/dbg_uart_cmd.sv
module dbg_uart_cmd
    import dbg_uart_pkg::*;
(
    input  logic             we_i,
    input  logic [CMD_W-1:0] wdata_i,
    output dir_cmd_t         tx_cmd_o,
    output dir_cmd_t         rx_cmd_o,
    output logic             sta_clr_o
);
    // Reset outranks disable, disable masks enable.
    always_comb begin
        tx_cmd_o.rst = we_i & wdata_i[CMD_TX_RST];
        tx_cmd_o.dis = we_i & wdata_i[CMD_TX_DIS] & ~wdata_i[CMD_TX_RST];
        tx_cmd_o.en  = we_i & wdata_i[CMD_TX_EN]  & ~wdata_i[CMD_TX_DIS] & ~wdata_i[CMD_TX_RST];
        rx_cmd_o.rst = we_i & wdata_i[CMD_RX_RST];
        rx_cmd_o.dis = we_i & wdata_i[CMD_RX_DIS] & ~wdata_i[CMD_RX_RST];
        rx_cmd_o.en  = we_i & wdata_i[CMD_RX_EN]  & ~wdata_i[CMD_RX_DIS] & ~wdata_i[CMD_RX_RST];
        sta_clr_o    = we_i & wdata_i[CMD_STA_CLR];
    end
endmodule

// File: rtl/dbg_uart_tx.sv
module dbg_uart_tx
    import dbg_uart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dir_cmd_t          cmd_i,
    input  logic              tick_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              txd_o,
    output logic              ready_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam int BIT_W = $clog2(DATA_W);

    typedef struct packed {
        logic              on;
        logic              stop_pend;
        logic              hold_vld;
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] shft;
        logic              par_bit;
        logic              par_on;
        frame_st_e         st;
        logic [CNT_W-1:0]  tcnt;
        logic [BIT_W-1:0]  bcnt;
    } tx_state_t;

    tx_state_t q, d;

    assign ready_o = q.on & ~q.stop_pend & ~q.hold_vld;

    always_comb begin
        case (q.st)
            FR_START: txd_o = 1'b0;
            FR_DATA:  txd_o = q.shft[0];
            FR_PAR:   txd_o = q.par_bit;
            default:  txd_o = 1'b1;
        endcase
    end

    always_comb begin
        d = q;
        // Bit timing
        if (q.st != FR_IDLE && tick_i) begin
            if (q.tcnt == CNT_W'(OSR - 1)) begin
                d.tcnt = '0;
                case (q.st)
                    FR_START: begin
                        d.st   = FR_DATA;
                        d.bcnt = '0;
                    end
                    FR_DATA: begin
                        d.shft = q.shft >> 1;
                        if (q.bcnt == BIT_W'(DATA_W - 1))
                            d.st = q.par_on ? FR_PAR : FR_STOP;
                        else
                            d.bcnt = q.bcnt + 1'b1;
                    end
                    FR_PAR:  d.st = FR_STOP;
                    default: d.st = FR_IDLE;
                endcase
            end else begin
                d.tcnt = q.tcnt + 1'b1;
            end
        end
        // Launch the held byte
        if (q.st == FR_IDLE && q.hold_vld && q.on) begin
            d.st       = FR_START;
            d.shft     = q.hold;
            d.hold_vld = 1'b0;
            d.tcnt     = '0;
            d.par_on   = par_en_i;
            d.par_bit  = par_odd_i ^ (^q.hold);
        end
        // Holding register write
        if (wr_i && ready_o) begin
            d.hold     = wdata_i;
            d.hold_vld = 1'b1;
        end
        // Deferred disable completes once everything has drained
        if (q.stop_pend && q.st == FR_IDLE && !q.hold_vld) begin
            d.on        = 1'b0;
            d.stop_pend = 1'b0;
        end
        // Commands
        if (cmd_i.dis) begin
            if (d.st != FR_IDLE || d.hold_vld) d.stop_pend = 1'b1;
            else                               d.on        = 1'b0;
        end
        if (cmd_i.en) begin
            d.on        = 1'b1;
            d.stop_pend = 1'b0;
        end
        if (cmd_i.rst) begin
            d.on        = 1'b0;
            d.stop_pend = 1'b0;
            d.hold_vld  = 1'b0;
            d.st        = FR_IDLE;
            d.tcnt      = '0;
            d.bcnt      = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/dbg_uart_rx.sv
module dbg_uart_rx
    import dbg_uart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dir_cmd_t          cmd_i,
    input  logic              sta_clr_i,
    input  logic              tick_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              rxd_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o,
    output logic              pe_o,
    output logic              fe_o,
    output logic              oe_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam int BIT_W = $clog2(DATA_W);
    localparam int HALF  = OSR / 2;

    typedef struct packed {
        logic [1:0]        sync;
        logic              on;
        logic              stop_pend;
        frame_st_e         st;
        logic [CNT_W-1:0]  tcnt;
        logic [BIT_W-1:0]  bcnt;
        logic [DATA_W-1:0] shft;
        logic              par_on;
        logic              par_odd;
        logic              par_rx;
        logic [DATA_W-1:0] data;
        logic              ready;
        logic              pe;
        logic              fe;
        logic              oe;
    } rx_state_t;

    rx_state_t q, d;
    logic      rxs;

    assign rxs     = q.sync[1];
    assign data_o  = q.data;
    assign ready_o = q.ready;
    assign pe_o    = q.pe;
    assign fe_o    = q.fe;
    assign oe_o    = q.oe;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], rxd_i};
        if (rd_i) d.ready = 1'b0;
        if (tick_i) begin
            case (q.st)
                FR_IDLE: begin
                    if (q.on && !q.stop_pend && !rxs) begin
                        d.st      = FR_START;
                        d.tcnt    = '0;
                        d.par_on  = par_en_i;
                        d.par_odd = par_odd_i;
                    end
                end
                FR_START: begin
                    if (q.tcnt == CNT_W'(HALF - 1)) begin
                        d.tcnt = '0;
                        d.bcnt = '0;
                        d.st   = rxs ? FR_IDLE : FR_DATA;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                default: begin
                    if (q.tcnt == CNT_W'(OSR - 1)) begin
                        d.tcnt = '0;
                        if (q.st == FR_DATA) begin
                            d.shft = {rxs, q.shft[DATA_W-1:1]};
                            if (q.bcnt == BIT_W'(DATA_W - 1))
                                d.st = q.par_on ? FR_PAR : FR_STOP;
                            else
                                d.bcnt = q.bcnt + 1'b1;
                        end else if (q.st == FR_PAR) begin
                            d.par_rx = rxs;
                            d.st     = FR_STOP;
                        end else begin
                            d.data  = q.shft;
                            d.ready = 1'b1;
                            if (q.ready && !rd_i) d.oe = 1'b1;
                            if (!rxs) d.fe = 1'b1;
                            if (q.par_on && (q.par_rx != (q.par_odd ^ (^q.shft))))
                                d.pe = 1'b1;
                            d.st = FR_IDLE;
                        end
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
            endcase
        end
        // Deferred disable completes at the first idle cycle
        if (q.stop_pend && q.st == FR_IDLE) begin
            d.on        = 1'b0;
            d.stop_pend = 1'b0;
        end
        if (cmd_i.dis) begin
            if (d.st != FR_IDLE) d.stop_pend = 1'b1;
            else                 d.on        = 1'b0;
        end
        if (cmd_i.en) begin
            d.on        = 1'b1;
            d.stop_pend = 1'b0;
        end
        if (cmd_i.rst) begin
            d.on        = 1'b0;
            d.stop_pend = 1'b0;
            d.st        = FR_IDLE;
            d.tcnt      = '0;
            d.bcnt      = '0;
        end
        if (sta_clr_i) begin
            d.pe = 1'b0;
            d.fe = 1'b0;
            d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dbg_uart.sv
module dbg_uart
    import dbg_uart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              thr_we,
    input  logic [DATA_W-1:0] thr_wdata,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              baud_tick,
    input  logic              rxd,
    input  logic              rx_rd,
    output logic              txd,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              par_err,
    output logic              frm_err,
    output logic              ovr_err
);
    dir_cmd_t tx_cmd, rx_cmd;
    logic     sta_clr;

    dbg_uart_cmd u_cmd (
        .we_i      (cmd_we),
        .wdata_i   (cmd_wdata),
        .tx_cmd_o  (tx_cmd),
        .rx_cmd_o  (rx_cmd),
        .sta_clr_o (sta_clr)
    );

    dbg_uart_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (tx_cmd),
        .tick_i    (baud_tick),
        .par_en_i  (par_en),
        .par_odd_i (par_odd),
        .wr_i      (thr_we),
        .wdata_i   (thr_wdata),
        .txd_o     (txd),
        .ready_o   (tx_ready)
    );

    dbg_uart_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (rx_cmd),
        .sta_clr_i (sta_clr),
        .tick_i    (baud_tick),
        .par_en_i  (par_en),
        .par_odd_i (par_odd),
        .rxd_i     (rxd),
        .rd_i      (rx_rd),
        .data_o    (rx_data),
        .ready_o   (rx_ready),
        .pe_o      (par_err),
        .fe_o      (frm_err),
        .oe_o      (ovr_err)
    );
endmodule

// File: rtl/dbg_uart_chk.sv
module dbg_uart_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_rst_wr,
    input logic tx_en_dis_wr,
    input logic sta_clr_wr,
    input logic rx_rd,
    input logic txd,
    input logic tx_ready,
    input logic rx_ready,
    input logic par_err,
    input logic frm_err,
    input logic ovr_err
);
    a_r2_tx_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst_wr |=> (txd && !tx_ready));

    a_r5_tx_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tx_rst_wr |=> !tx_ready);

    a_r4_masked_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_dis_wr && !tx_ready) |=> !tx_ready);

    a_r12_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
        sta_clr_wr |=> (!par_err && !frm_err && !ovr_err));

    a_r11_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err) |-> ($past(rx_ready) && !$past(rx_rd)));
endmodule

bind dbg_uart dbg_uart_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_rst_wr    (cmd_we && cmd_wdata[3]),
    .tx_en_dis_wr (cmd_we && cmd_wdata[6] && cmd_wdata[7]),
    .sta_clr_wr   (cmd_we && cmd_wdata[8]),
    .rx_rd        (rx_rd),
    .txd          (txd),
    .tx_ready     (tx_ready),
    .rx_ready     (rx_ready),
    .par_err      (par_err),
    .frm_err      (frm_err),
    .ovr_err      (ovr_err)
);

// File: tb/tb_dbg_uart.sv
module tb_dbg_uart;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [8:0] cmd_wdata = '0;
    logic       thr_we = 1'b0;
    logic [7:0] thr_wdata = '0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_rd = 1'b0;
    logic       txd, tx_ready, rx_ready, par_err, frm_err, ovr_err;
    logic [7:0] rx_data;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [7:0] cap_d, cap_d2;
    logic       cap_p, cap_s, cap_ok, cap_p2, cap_s2, cap_ok2;

    dbg_uart dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .thr_we(thr_we), .thr_wdata(thr_wdata), .par_en(par_en), .par_odd(par_odd),
        .baud_tick(baud_tick), .rxd(rxd), .rx_rd(rx_rd), .txd(txd), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_ready(rx_ready), .par_err(par_err), .frm_err(frm_err),
        .ovr_err(ovr_err)
    );

    always #5 clk = ~clk;

    initial begin : tick_gen
        int c = 0;
        forever begin
            @(negedge clk);
            c = (c + 1) % 4;
            baud_tick = (c == 0);
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog (all): actual hung expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    function automatic logic exp_par(input logic [7:0] v, input logic odd);
        return odd ^ (^v);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!baud_tick) @(posedge clk);
        end
    endtask

    task automatic cmd(input logic [8:0] v);
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = v;
        @(negedge clk); cmd_we = 1'b0; cmd_wdata = '0;
    endtask

    task automatic thr_write(input logic [7:0] v);
        @(negedge clk); thr_we = 1'b1; thr_wdata = v;
        @(negedge clk); thr_we = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic rx_bit(input logic v);
        @(negedge clk); rxd = v;
        wait_ticks(16);
    endtask

    task automatic rx_frame(input logic [7:0] v, input logic pen, input logic pbit, input logic stop);
        rx_bit(1'b0);
        for (int i = 0; i < 8; i++) rx_bit(v[i]);
        if (pen) rx_bit(pbit);
        rx_bit(stop);
        @(negedge clk); rxd = 1'b1;
    endtask

    task automatic tx_capture(input logic pen, output logic [7:0] d, output logic p,
                              output logic s, output logic ok);
        int guard = 0;
        ok = 1'b1; d = '0; p = 1'b0; s = 1'b0;
        while (txd === 1'b1 && guard < 20000) begin
            @(negedge clk); guard++;
        end
        if (guard >= 20000) begin
            ok = 1'b0;
            return;
        end
        wait_ticks(8);
        for (int i = 0; i < 8; i++) begin
            wait_ticks(16); @(negedge clk); d[i] = txd;
        end
        if (pen) begin
            wait_ticks(16); @(negedge clk); p = txd;
        end
        wait_ticks(16); @(negedge clk); s = txd;
    endtask

    task automatic watch_txd_idle(input int cycles, input string req);
        int lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        check(req, lows, 0);
    endtask

    initial begin : stim
        logic [7:0] v;
        logic pe, po;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R13 reset tx_ready", tx_ready, 0);
        check("R2 reset txd", txd, 1);
        check("R9 reset rx_ready", rx_ready, 0);
        check("R10 reset flags", {par_err, frm_err, ovr_err}, 0);

        cmd(9'h050);                      // enable both directions
        check("R13 tx_ready after enable", tx_ready, 1);
        cmd(9'h003);                      // bits 0/1 only: no effect
        check("R1 unused bits keep tx_ready", tx_ready, 1);

        // Basic receive, overrun, status clear, read
        rx_frame(8'hA5, 1'b0, 1'b0, 1'b1);
        check("R9 rx_data", rx_data, 8'hA5);
        check("R9 rx_ready", rx_ready, 1);
        rx_frame(8'h11, 1'b0, 1'b0, 1'b1);
        check("R11 overrun flag", ovr_err, 1);
        check("R11 newest byte", rx_data, 8'h11);
        cmd(9'h100);
        check("R12 flags cleared", {par_err, frm_err, ovr_err}, 0);
        check("R12 rx_ready kept", rx_ready, 1);
        rd_pulse();
        check("R14 read clears ready", rx_ready, 0);

        // Framing error; trailing low then idle exercises false-start rejection
        rx_frame(8'h3C, 1'b0, 1'b0, 1'b0);
        wait_ticks(32);
        check("R10 framing error", frm_err, 1);
        check("R10 byte kept", rx_data, 8'h3C);
        check("R9 no spurious frame after low stop", ovr_err, 0);
        cmd(9'h100); rd_pulse();

        // Parity error, then correct odd parity
        par_en = 1'b1; par_odd = 1'b0;
        rx_frame(8'h0F, 1'b1, 1'b1, 1'b1);
        check("R10 parity error", par_err, 1);
        cmd(9'h100); rd_pulse();
        par_odd = 1'b1;
        rx_frame(8'h0F, 1'b1, exp_par(8'h0F, 1'b1), 1'b1);
        check("R10 good odd parity", par_err, 0);
        check("R10 good odd parity data", rx_data, 8'h0F);
        rd_pulse();
        par_en = 1'b0; par_odd = 1'b0;

        // False start: short low pulse
        @(negedge clk); rxd = 1'b0;
        wait_ticks(4);
        @(negedge clk); rxd = 1'b1;
        wait_ticks(40);
        check("R9 false start rejected", rx_ready, 0);

        // Receiver reset mid-frame
        rx_bit(1'b0); rx_bit(1'b1); rx_bit(1'b0); rx_bit(1'b1);
        cmd(9'h004);
        for (int i = 0; i < 6; i++) rx_bit(1'b1);
        @(negedge clk); rxd = 1'b1;
        wait_ticks(20);
        check("R3 partial frame discarded", rx_ready, 0);
        rx_frame(8'h77, 1'b0, 1'b0, 1'b1);
        check("R3 receiver left disabled", rx_ready, 0);
        cmd(9'h030);
        rx_frame(8'h66, 1'b0, 1'b0, 1'b1);
        check("R4 rx enable masked by disable", rx_ready, 0);
        cmd(9'h014);
        rx_frame(8'h55, 1'b0, 1'b0, 1'b1);
        check("R5 rx reset beats enable", rx_ready, 0);
        cmd(9'h010);
        rx_frame(8'h5A, 1'b0, 1'b0, 1'b1);
        check("R1 rx enable bit 4", rx_data, 8'h5A);
        check("R1 rx enable ready", rx_ready, 1);
        rd_pulse();

        // Graceful receiver disable
        rx_bit(1'b0); rx_bit(1'b0); rx_bit(1'b1);
        cmd(9'h020);
        rx_bit(1'b1); rx_bit(1'b0); rx_bit(1'b0); rx_bit(1'b1); rx_bit(1'b1); rx_bit(1'b0);
        rx_bit(1'b1);
        @(negedge clk); rxd = 1'b1;
        check("R7 in-flight frame delivered", rx_ready, 1);
        check("R7 in-flight frame data", rx_data, 8'h66);
        rd_pulse();
        rx_frame(8'h99, 1'b0, 1'b0, 1'b1);
        check("R7 later frame ignored", rx_ready, 0);
        cmd(9'h010);

        // Graceful transmitter disable: shifting byte and held byte both sent
        thr_write(8'hC3);
        fork
            begin
                tx_capture(1'b0, cap_d, cap_p, cap_s, cap_ok);
                tx_capture(1'b0, cap_d2, cap_p2, cap_s2, cap_ok2);
            end
            begin
                while (txd === 1'b1) @(negedge clk);
                thr_write(8'h3A);
                cmd(9'h080);
            end
        join
        check("R6 first byte", {cap_ok, cap_d, cap_s}, {1'b1, 8'hC3, 1'b1});
        check("R6 held byte", {cap_ok2, cap_d2, cap_s2}, {1'b1, 8'h3A, 1'b1});
        wait_ticks(16);
        check("R6 stopped after drain", tx_ready, 0);
        thr_write(8'h81);
        watch_txd_idle(600, "R13 write while disabled not sent");
        cmd(9'h040);
        check("R13 ready after re-enable", tx_ready, 1);
        watch_txd_idle(300, "R13 ignored byte not held");

        // Transmitter reset mid-frame
        thr_write(8'h00);
        while (txd === 1'b1) @(negedge clk);
        wait_ticks(40);
        cmd(9'h008);
        check("R2 txd idle after reset", txd, 1);
        check("R2 tx disabled after reset", tx_ready, 0);
        watch_txd_idle(300, "R2 frame cut off");
        cmd(9'h048);
        check("R5 tx reset beats enable", tx_ready, 0);
        cmd(9'h0C0);
        check("R4 tx enable masked by disable", tx_ready, 0);
        cmd(9'h003);
        check("R1 unused bits no effect", tx_ready, 0);
        cmd(9'h040);
        check("R1 tx enable bit 6", tx_ready, 1);

        // Random frames in both directions
        for (int n = 0; n < 10; n++) begin
            v  = 8'($urandom);
            pe = 1'($urandom);
            po = 1'($urandom);
            par_en = pe; par_odd = po;
            @(negedge clk);
            thr_write(v);
            tx_capture(pe, cap_d, cap_p, cap_s, cap_ok);
            check("R8 tx data", {cap_ok, cap_d}, {1'b1, v});
            if (pe) check("R8 tx parity", cap_p, exp_par(v, po));
            check("R8 tx stop", cap_s, 1);
            wait_ticks(16);
            v = 8'($urandom);
            rx_frame(v, pe, exp_par(v, po), 1'b1);
            check("R9 random rx data", {rx_ready, rx_data}, {1'b1, v});
            check("R10 random rx no errors", {par_err, frm_err, ovr_err}, 0);
            rd_pulse();
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule